// File: doc/BRIEF.md
# OUT Endpoint Receive Buffer Occupancy Tracker

This block keeps the fill state of one receive buffer behind a USB OUT endpoint and reports it to firmware as a 2-bit status code. The serial engine pulses `pkt_done` once for each good packet it has stored and gives the packet length with it. Firmware drains the buffer, then either writes a one to a clear bit (`clr_wr`) or relies on the hardware to step the status down when it signals `unload_done`.

The buffer runs as one slot or as two slots. A "data set" is the unit the status counts. With continuous transfer off, every packet is one data set. With continuous transfer on, packets are summed into one set. That set closes when the running byte total reaches the configured buffer size, or when a packet shorter than the maximum packet size arrives. A packet offered while the buffer is already full is dropped, and this sets a sticky overrun flag.

Top module: `rxbuf_occupancy`

## Requirements
- R1: A synchronous active-high reset sets `buf_sts` to 00 and `overrun` to 0, and clears the byte accumulator. After reset, a continuous-mode set therefore needs the full buffer size again.
- R2: In single-slot mode (`cfg_dual`=0), completing a set moves `buf_sts` from 00 to 11, and a step-down moves it from 11 to 00.
- R3: In two-slot mode (`cfg_dual`=1), the first completed set moves `buf_sts` from 00 to 10 and the second moves it from 10 to 11. The status never jumps from 00 to 11.
- R4: In two-slot mode, each step-down moves `buf_sts` from 11 to 10, or from 10 to 00.
- R5: With `cfg_autoclr`=0, only a `clr_wr` pulse steps the status down. `unload_done` has no effect.
- R6: With `cfg_autoclr`=1, an `unload_done` pulse steps the status down. `clr_wr` has no effect.
- R7: With `cfg_cont`=0, every accepted `pkt_done` completes one set, whatever its length.
- R8: With `cfg_cont`=1, a packet that is not short adds its length to an accumulator. The set completes on the packet that brings the total to `cfg_bufsize` or beyond, and the accumulator then returns to zero.
- R9: With `cfg_cont`=1, a packet whose `pkt_len` is below `cfg_maxpkt` completes the set at once. This includes a zero-length packet.
- R10: A `pkt_done` that arrives while the buffer is full leaves the status and the accumulator unchanged and sets `overrun`. `overrun` stays at 1 until reset. Full means 11 in either mode.
- R11: When a set completes in the same cycle as an effective step-down, `buf_sts` keeps its value.
- R12: A step-down request while `buf_sts` is 00 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual | input | 1 | 1 = two-slot buffering, 0 = single slot |
| cfg_autoclr | input | 1 | 1 = hardware steps down on unload_done |
| cfg_cont | input | 1 | 1 = packets accumulate into one data set |
| cfg_bufsize | input | SIZE_W | Buffer size in bytes (nonzero) |
| cfg_maxpkt | input | LEN_W | Maximum packet size in bytes |
| pkt_done | input | 1 | One-cycle pulse per good received packet |
| pkt_len | input | LEN_W | Byte count of the packet, valid with pkt_done |
| unload_done | input | 1 | Firmware finished draining one set |
| clr_wr | input | 1 | Firmware wrote one to the clear bit |
| buf_sts | output | 2 | Occupancy code: 00 empty, 10 one set, 11 full |
| overrun | output | 1 | Sticky flag for a packet offered while full |

## Verification
The assertions assume that the configuration inputs change only in a cycle where reset is high, and that `cfg_bufsize` is nonzero. Under those conditions, the single-slot code 10 and jumps between non-adjacent codes cannot occur, and the accumulator always stays below the buffer size. The stimulus applies every new configuration together with a reset pulse, uses a 64-byte buffer and 16-byte maximum packets, and keeps all strobes one cycle wide.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

    typedef enum logic [1:0] {
        LVL_EMPTY = 2'd0,
        LVL_ONE   = 2'd1,
        LVL_TWO   = 2'd2
    } lvl_e;

    localparam logic [1:0] STS_EMPTY = 2'b00;
    localparam logic [1:0] STS_ONE   = 2'b10;
    localparam logic [1:0] STS_FULL  = 2'b11;

    // Map the internal fill level to the firmware-visible code.
    function automatic logic [1:0] lvl_to_sts(input lvl_e lvl, input logic dual);
        if (lvl == LVL_EMPTY)
            return STS_EMPTY;
        else if (!dual || lvl == LVL_TWO)
            return STS_FULL;
        else
            return STS_ONE;
    endfunction

endpackage

// File: rtl/rxbuf_setacc.sv
module rxbuf_setacc #(
    parameter int LEN_W  = 11,
    parameter int SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_cont,
    input  logic [SIZE_W-1:0] cfg_bufsize,
    input  logic [LEN_W-1:0]  cfg_maxpkt,
    input  logic              accept,
    input  logic [LEN_W-1:0]  pkt_len,
    output logic              set_done
);
    localparam int SUM_W = ((SIZE_W > LEN_W) ? SIZE_W : LEN_W) + 1;

    logic [SIZE_W-1:0] acc_q;
    logic [SUM_W-1:0]  sum;
    logic              is_short;
    logic              reach;

    always_comb begin
        sum      = SUM_W'(acc_q) + SUM_W'(pkt_len);
        is_short = pkt_len < cfg_maxpkt;
        reach    = sum >= SUM_W'(cfg_bufsize);
        set_done = accept && (!cfg_cont || is_short || reach);
    end

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (set_done)
            acc_q <= '0;
        else if (accept)
            acc_q <= sum[SIZE_W-1:0];
    end

    // R8: the partial total never reaches the buffer size.
    p_acc_range_r8: assert property (@(posedge clk) disable iff (rst)
        acc_q < cfg_bufsize);

    // R1: the accumulator is empty in the cycle after reset.
    p_acc_reset_r1: assert property (@(posedge clk)
        rst |=> acc_q == '0);

endmodule

// File: rtl/rxbuf_level.sv
module rxbuf_level
    import rxbuf_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_dual,
    input  logic       set_done,
    input  logic       stepdown_req,
    output logic       full,
    output logic [1:0] sts
);
    lvl_e lvl_q, lvl_d;
    logic dec;

    always_comb begin
        dec   = stepdown_req && (lvl_q != LVL_EMPTY);
        lvl_d = lvl_q;
        unique case ({set_done, dec})
            2'b10:   lvl_d = (lvl_q == LVL_EMPTY) ? LVL_ONE : LVL_TWO;
            2'b01:   lvl_d = (lvl_q == LVL_TWO) ? LVL_ONE : LVL_EMPTY;
            default: lvl_d = lvl_q;
        endcase
        full = cfg_dual ? (lvl_q == LVL_TWO) : (lvl_q != LVL_EMPTY);
        sts  = lvl_to_sts(lvl_q, cfg_dual);
    end

    always_ff @(posedge clk) begin
        if (rst)
            lvl_q <= LVL_EMPTY;
        else
            lvl_q <= lvl_d;
    end

    // R3: two-slot mode never jumps from empty to full.
    p_dual_no_jump_r3: assert property (@(posedge clk) disable iff (rst)
        (cfg_dual && sts == STS_EMPTY) |=> sts != STS_FULL);

    // R12: with no completion, an empty buffer stays empty.
    p_empty_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (sts == STS_EMPTY && !set_done) |=> sts == STS_EMPTY);

    // R11: completion together with an effective step-down keeps the code.
    p_both_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (set_done && stepdown_req && sts != STS_EMPTY) |=> $stable(sts));

endmodule

// File: rtl/rxbuf_occupancy.sv
module rxbuf_occupancy #(
    parameter int LEN_W  = 11,
    parameter int SIZE_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_dual,
    input  logic              cfg_autoclr,
    input  logic              cfg_cont,
    input  logic [SIZE_W-1:0] cfg_bufsize,
    input  logic [LEN_W-1:0]  cfg_maxpkt,
    input  logic              pkt_done,
    input  logic [LEN_W-1:0]  pkt_len,
    input  logic              unload_done,
    input  logic              clr_wr,
    output logic [1:0]        buf_sts,
    output logic              overrun
);
    logic full;
    logic accept;
    logic set_done;
    logic stepdown_req;
    logic ovr_q;

    always_comb begin
        accept       = pkt_done && !full;
        stepdown_req = cfg_autoclr ? unload_done : clr_wr;
    end

    rxbuf_setacc #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) u_acc (
        .clk         (clk),
        .rst         (rst),
        .cfg_cont    (cfg_cont),
        .cfg_bufsize (cfg_bufsize),
        .cfg_maxpkt  (cfg_maxpkt),
        .accept      (accept),
        .pkt_len     (pkt_len),
        .set_done    (set_done)
    );

    rxbuf_level u_lvl (
        .clk          (clk),
        .rst          (rst),
        .cfg_dual     (cfg_dual),
        .set_done     (set_done),
        .stepdown_req (stepdown_req),
        .full         (full),
        .sts          (buf_sts)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ovr_q <= 1'b0;
        else if (pkt_done && full)
            ovr_q <= 1'b1;
    end

    assign overrun = ovr_q;

    // R10: a packet offered while full raises overrun and keeps the status.
    p_full_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (pkt_done && buf_sts == 2'b11 && !stepdown_req) |=> (overrun && buf_sts == 2'b11));

    // R10: overrun is sticky.
    p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

    // R7: with continuous mode off, every accepted packet closes a set.
    p_cont_off_r7: assert property (@(posedge clk) disable iff (rst)
        (!cfg_cont && pkt_done && !full) |-> set_done);

    // R5: without auto-clear and without a clear write, a held set stays.
    p_manual_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (!cfg_autoclr && !clr_wr && !pkt_done) |=> $stable(buf_sts));

    // R6: with auto-clear, the clear bit alone never lowers the status.
    p_auto_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (cfg_autoclr && !unload_done && !pkt_done) |=> $stable(buf_sts));

endmodule

// File: tb/sim_rxbuf_occupancy.sv
module sim_rxbuf_occupancy;
    localparam int LEN_W  = 11;
    localparam int SIZE_W = 12;

    typedef struct {
        logic [1:0] sts;
        logic       ovr;
        string      tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_dual = 1'b0, cfg_autoclr = 1'b0, cfg_cont = 1'b0;
    logic [SIZE_W-1:0] cfg_bufsize = 12'd64;
    logic [LEN_W-1:0]  cfg_maxpkt = 11'd16;
    logic              pkt_done = 1'b0, unload_done = 1'b0, clr_wr = 1'b0;
    logic [LEN_W-1:0]  pkt_len = '0;
    logic [1:0]        buf_sts;
    logic              overrun;

    int   n_run = 0, n_fail = 0;
    exp_t sb[$];
    bit   finished = 1'b0;

    always #4 clk = ~clk;

    rxbuf_occupancy #(.LEN_W(LEN_W), .SIZE_W(SIZE_W)) u0 (
        .clk(clk), .rst(rst), .cfg_dual(cfg_dual), .cfg_autoclr(cfg_autoclr),
        .cfg_cont(cfg_cont), .cfg_bufsize(cfg_bufsize), .cfg_maxpkt(cfg_maxpkt),
        .pkt_done(pkt_done), .pkt_len(pkt_len), .unload_done(unload_done),
        .clr_wr(clr_wr), .buf_sts(buf_sts), .overrun(overrun)
    );

    // Monitor: compare registered outputs shortly after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_run++;
                if (buf_sts !== e.sts || overrun !== e.ovr) begin
                    n_fail++;
                    $display("FAIL %s: sts=%b ovr=%b expected sts=%b ovr=%b",
                             e.tag, buf_sts, overrun, e.sts, e.ovr);
                end
            end
        end
    end

    // Driver: one cycle of stimulus plus the expected post-edge outputs.
    task automatic step(input logic r, input logic pd, input int len,
                        input logic ul, input logic cw,
                        input logic [1:0] es, input logic eo, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; pkt_done = pd; pkt_len = LEN_W'(len);
        unload_done = ul; clr_wr = cw;
        e.sts = es; e.ovr = eo; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic reconfig(input logic d, input logic a, input logic c);
        exp_t e;
        @(negedge clk);
        cfg_dual = d; cfg_autoclr = a; cfg_cont = c;
        rst = 1'b1; pkt_done = 1'b0; unload_done = 1'b0; clr_wr = 1'b0;
        e.sts = 2'b00; e.ovr = 1'b0; e.tag = "R1 reset";
        sb.push_back(e);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // Single slot, manual clear, per-packet sets.
        reconfig(1'b0, 1'b0, 1'b0);
        step(0, 1, 16, 0, 0, 2'b11, 0, "R2 R7 single fill");
        step(0, 1, 16, 0, 0, 2'b11, 1, "R10 packet while full");
        step(0, 0, 0,  0, 0, 2'b11, 1, "R10 overrun sticky");
        step(0, 0, 0,  1, 0, 2'b11, 1, "R5 unload ignored without autoclr");
        step(0, 0, 0,  0, 1, 2'b00, 1, "R2 R5 clear write empties");
        step(0, 0, 0,  0, 1, 2'b00, 1, "R12 clear while empty");
        step(0, 1, 3,  0, 0, 2'b11, 1, "R7 short packet is one set");

        // Two slots, auto-clear, per-packet sets.
        reconfig(1'b1, 1'b1, 1'b0);
        step(0, 1, 16, 0, 0, 2'b10, 0, "R3 first set");
        step(0, 1, 16, 0, 0, 2'b11, 0, "R3 second set");
        step(0, 1, 16, 0, 0, 2'b11, 1, "R10 third packet dropped");
        step(0, 0, 0,  0, 1, 2'b11, 1, "R6 clear write ignored");
        step(0, 0, 0,  1, 0, 2'b10, 1, "R4 R6 unload 11 to 10");
        step(0, 1, 16, 1, 0, 2'b10, 1, "R11 complete and unload together");
        step(0, 0, 0,  1, 0, 2'b00, 1, "R4 unload 10 to 00");
        step(0, 0, 0,  1, 0, 2'b00, 1, "R12 unload while empty");
        step(0, 1, 0,  0, 0, 2'b10, 1, "R7 zero-length packet");

        // Two slots, manual clear, continuous sets of 64 bytes.
        reconfig(1'b1, 1'b0, 1'b1);
        step(0, 1, 16, 0, 0, 2'b00, 0, "R8 accumulate 16");
        step(0, 1, 16, 0, 0, 2'b00, 0, "R8 accumulate 32");
        step(0, 1, 16, 0, 0, 2'b00, 0, "R8 accumulate 48");
        step(0, 1, 16, 0, 0, 2'b10, 0, "R8 reach buffer size");
        step(0, 1, 5,  0, 0, 2'b11, 0, "R9 short packet closes set");
        step(0, 0, 0,  0, 1, 2'b10, 0, "R4 R5 clear write 11 to 10");
        step(0, 1, 16, 0, 0, 2'b10, 0, "R8 new partial set");
        step(1, 0, 0,  0, 0, 2'b00, 0, "R1 reset mid set");
        step(0, 1, 16, 0, 0, 2'b00, 0, "R1 accumulator restarted 16");
        step(0, 1, 16, 0, 0, 2'b00, 0, "R1 accumulator restarted 32");
        step(0, 1, 16, 0, 0, 2'b00, 0, "R1 accumulator restarted 48");
        step(0, 1, 16, 0, 0, 2'b10, 0, "R1 R8 full set after reset");
        step(0, 1, 0,  0, 0, 2'b11, 0, "R9 zero-length closes set");
        step(0, 1, 16, 0, 1, 2'b10, 1, "R10 R5 drop while full then clear");

        step(0, 0, 0, 0, 0, 2'b10, 1, "R10 idle hold");
        @(posedge clk);
        #3;
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule